// File: doc/BRIEF.md
# Translation Query Validation Sequencer

This block screens a single address-translation query before any table walk starts. It first checks the request on its own: the lookup type, the kind of issuing interface, which stages the hardware implements, and whether a substream is named. Then it asks an external configuration fetch unit for the stream-table entry and, if needed, for the context descriptor. It checks each response in a fixed priority order. It stops at the first problem it finds and reports an 8-bit fault code. If no check fails, it reports code 0x00, which means the table walk may proceed.

A query is started by pulsing `req_valid` while the block is idle. Each fetch is requested by holding `ste_req` or `cd_req` high. The responder answers with a one-cycle `*_rsp_valid` strobe and places the response fields beside it. A one-cycle `done` pulse marks the result. `result_code` and `fault` keep their values until the next query is accepted. `sel_vmid` and the capability inputs are static configuration.

Lookup type encoding: 2'b00 is reserved, 2'b01 is stage 1, 2'b10 is stage 2 only, and 2'b11 is both stages.

Top module: `xlat_query_checker`

## Requirements
- R1: Type 2'b00 ends the query with code 0xFF in the cycle after acceptance, with no fetch request.
- R2: A type that needs stage 1 when `cap_s1`=0, or stage 2 when `cap_s2`=0, gives 0xFF with no fetch.
- R3: On the virtual interface (`req_virt`=1), types 2'b10 and 2'b11 give 0xFF with no fetch.
- R4: Type 2'b10 with `ssid_valid`=1 gives 0xFF with no fetch.
- R5: A secure query (`req_secure`=1) that needs stage 2 while `cap_sec_s2`=0, and passes the R1–R4 screens, gives 0xFE with no fetch. Secure stage-1 queries are not affected by this check.
- R6: After the entry arrives, the checks run in this order: `ste_sid_ok`=0 gives 0x02, then `ste_abort`=1 gives 0x03, then `ste_valid`=0 gives 0x04.
- R7: On the virtual interface, a valid entry that has `ste_vmid_tag`=0, or whose `ste_vmid` differs from `sel_vmid`, gives 0x04. This check ranks above the stage check.
- R8: A valid entry that does not enable every stage the type asks for (`ste_s1_en` for type bit 0, `ste_s2_en` for type bit 1) gives 0xFE.
- R9: For types that use stage 1, the substream checks follow. First, `ssid_valid`=1 with `ste_ssid_ok`=0 gives 0x08. Otherwise, stream-disabled gives 0x06. Stream-disabled applies when `ste_s1_en`=1 and `ste_cdmax_nz`=1, and also one of these holds: `ssid_valid`=0 with `ste_dss`=2'b00, or `ssid_valid`=1 with `ssid`=0 and `ste_dss`=2'b10.
- R10: Type 2'b10 skips the context fetch. So does a stage-1 bypass, which is `ssid_valid`=0, `ste_cdmax_nz`=1 and `ste_dss`=2'b01. Otherwise a context fetch follows, where `cd_abort`=1 gives 0x09 and then `cd_valid`=0 gives 0x0A.
- R11: The block never asks for both fetches at once, issues no fetch after a fault, and makes at most one request per fetch.
- R12: A query that passes every check ends with `done` for one cycle, `result_code`=0x00 and `fault`=0. Any nonzero code sets `fault`=1.
- R13: `req_valid` is ignored while `busy`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a query (accepted when idle) |
| req_type | input | 2 | Lookup type |
| req_virt | input | 1 | Query comes from the virtual interface |
| req_secure | input | 1 | Secure query for a secure stream |
| ssid_valid | input | 1 | Substream number is supplied |
| ssid | input | SSID_W | Substream number |
| cap_s1 | input | 1 | Stage 1 implemented |
| cap_s2 | input | 1 | Stage 2 implemented |
| cap_sec_s2 | input | 1 | Secure stage 2 implemented |
| sel_vmid | input | VMID_W | VMID the virtual interface is bound to |
| busy | output | 1 | Query in progress |
| ste_req | output | 1 | Stream-table entry fetch request |
| ste_rsp_valid | input | 1 | Entry response strobe |
| ste_sid_ok | input | 1 | Stream number within table |
| ste_abort | input | 1 | Entry fetch aborted |
| ste_valid | input | 1 | Entry valid |
| ste_s1_en | input | 1 | Entry enables stage 1 |
| ste_s2_en | input | 1 | Entry enables stage 2 |
| ste_vmid_tag | input | 1 | Entry tags translations with a VMID |
| ste_vmid | input | VMID_W | Entry VMID |
| ste_cdmax_nz | input | 1 | Entry has more than one context |
| ste_dss | input | 2 | Default-substream mode |
| ste_ssid_ok | input | 1 | Substream within context table |
| cd_req | output | 1 | Context descriptor fetch request |
| cd_rsp_valid | input | 1 | Context response strobe |
| cd_abort | input | 1 | Context fetch aborted |
| cd_valid | input | 1 | Context valid |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Result is a fault |
| result_code | output | 8 | Fault code, 0x00 means proceed |

## Verification
The priority chain is tested with queries in which several faults are present at once. The expected code is the highest-ranked one. This separates the static screens from each other and from the point-A stage check, and shows that the VMID check ranks above the stage check. The bench counts fetch strobes for every query. This shows whether a fault stopped the sequence early and whether the context fetch was skipped for stage-2 and bypass queries. Queries that succeed in each lookup type and mode make sure no check fires too widely. A second start pulse sent during a fetch confirms that a running query cannot be disturbed.

// File: rtl/xlat_query_checker.sv
module xlat_query_checker #(
  parameter int SSID_W = 20,
  parameter int VMID_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_type,
  input  logic              req_virt,
  input  logic              req_secure,
  input  logic              ssid_valid,
  input  logic [SSID_W-1:0] ssid,
  input  logic              cap_s1,
  input  logic              cap_s2,
  input  logic              cap_sec_s2,
  input  logic [VMID_W-1:0] sel_vmid,
  output logic              busy,
  output logic              ste_req,
  input  logic              ste_rsp_valid,
  input  logic              ste_sid_ok,
  input  logic              ste_abort,
  input  logic              ste_valid,
  input  logic              ste_s1_en,
  input  logic              ste_s2_en,
  input  logic              ste_vmid_tag,
  input  logic [VMID_W-1:0] ste_vmid,
  input  logic              ste_cdmax_nz,
  input  logic [1:0]        ste_dss,
  input  logic              ste_ssid_ok,
  output logic              cd_req,
  input  logic              cd_rsp_valid,
  input  logic              cd_abort,
  input  logic              cd_valid,
  output logic              done,
  output logic              fault,
  output logic [7:0]        result_code
);
  localparam logic [7:0] C_OK       = 8'h00;
  localparam logic [7:0] C_BADREQ   = 8'hFF;
  localparam logic [7:0] C_STAGE    = 8'hFE;
  localparam logic [7:0] C_SID      = 8'h02;
  localparam logic [7:0] C_STEABT   = 8'h03;
  localparam logic [7:0] C_BADSTE   = 8'h04;
  localparam logic [7:0] C_DISABLED = 8'h06;
  localparam logic [7:0] C_SSID     = 8'h08;
  localparam logic [7:0] C_CDABT    = 8'h09;
  localparam logic [7:0] C_BADCD    = 8'h0A;

  typedef enum logic [1:0] {S_IDLE, S_STE, S_CD} st_t;
  st_t st;

  logic [1:0]        typ_q;
  logic              virt_q, sv_q;
  logic [SSID_W-1:0] ssid_q;
  logic [7:0]        code_q;
  logic              done_q;

  wire accept = (st == S_IDLE) && req_valid;

  wire bad_req = (req_type == 2'b00) || (req_type[0] && !cap_s1) ||
                 (req_type[1] && !cap_s2) || (req_virt && req_type[1]) ||
                 (req_type == 2'b10 && ssid_valid);
  wire early_stage = req_secure && !cap_sec_s2 && req_type[1];

  wire uses_s1   = typ_q[0];
  wire vmid_bad  = virt_q && (!ste_vmid_tag || ste_vmid != sel_vmid);
  wire stage_bad = (typ_q[0] && !ste_s1_en) || (typ_q[1] && !ste_s2_en);
  wire ssid_bad  = uses_s1 && sv_q && !ste_ssid_ok;
  wire disabled  = uses_s1 && ste_s1_en && ste_cdmax_nz &&
                   ((!sv_q && ste_dss == 2'b00) ||
                    (sv_q && ssid_q == '0 && ste_dss == 2'b10));
  wire bypass    = !sv_q && ste_cdmax_nz && ste_dss == 2'b01;
  wire need_cd   = uses_s1 && !bypass;

  logic [7:0] ste_code, cd_code;
  always_comb begin
    if      (!ste_sid_ok) ste_code = C_SID;
    else if (ste_abort)   ste_code = C_STEABT;
    else if (!ste_valid)  ste_code = C_BADSTE;
    else if (vmid_bad)    ste_code = C_BADSTE;
    else if (stage_bad)   ste_code = C_STAGE;
    else if (ssid_bad)    ste_code = C_SSID;
    else if (disabled)    ste_code = C_DISABLED;
    else                  ste_code = C_OK;
  end
  assign cd_code = cd_abort ? C_CDABT : (!cd_valid ? C_BADCD : C_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      typ_q  <= 2'b00;
      virt_q <= 1'b0;
      sv_q   <= 1'b0;
      ssid_q <= '0;
      code_q <= C_OK;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          typ_q  <= req_type;
          virt_q <= req_virt;
          sv_q   <= ssid_valid;
          ssid_q <= ssid;
          if (bad_req) begin
            code_q <= C_BADREQ; done_q <= 1'b1;
          end else if (early_stage) begin
            code_q <= C_STAGE; done_q <= 1'b1;
          end else begin
            st <= S_STE;
          end
        end
        S_STE: if (ste_rsp_valid) begin
          if (ste_code != C_OK || !need_cd) begin
            code_q <= ste_code; done_q <= 1'b1; st <= S_IDLE;
          end else begin
            st <= S_CD;
          end
        end
        S_CD: if (cd_rsp_valid) begin
          code_q <= cd_code; done_q <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign ste_req     = (st == S_STE);
  assign cd_req      = (st == S_CD);
  assign done        = done_q;
  assign result_code = code_q;
  assign fault       = (code_q != C_OK);

  p_rsv_type_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_type == 2'b00 |=> done && result_code == 8'hFF && !ste_req);
  p_virt_deep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_virt && req_type[1] |=> done && result_code == 8'hFF && !ste_req);
  p_s2_ssid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_type == 2'b10 && ssid_valid |=> done && result_code == 8'hFF);
  p_early_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_type == 2'b10 && req_secure && !cap_sec_s2 && cap_s2 &&
    !ssid_valid && !req_virt |=> done && result_code == 8'hFE && !ste_req);
  p_cd_after_ste_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cd_req) |-> $past(ste_req));
  p_fetch_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ste_req && cd_req));
  p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ste_req && !cd_req);
  p_busy_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ste_rsp_valid && !cd_rsp_valid |=> busy && $stable(ste_req));
endmodule

// File: tb/xlat_query_checker_tb.sv
module xlat_query_checker_tb_top;
  localparam int PERIOD = 10;
  localparam logic T = 1'b1;
  localparam logic F = 1'b0;

  typedef struct packed {
    logic [1:0] typ;
    logic virt, sec, cs1, cs2, css2, sv;
    logic [3:0] ssid;
    logic sid_ok, s_ab, s_val, s1, s2, vtag;
    logic [3:0] vmid;
    logic cdnz;
    logic [1:0] dss;
    logic ssid_ok, c_ab, c_val;
    logic [7:0] exp;
    logic [1:0] nf;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    // typ  virt sec cs1 cs2 css2 sv ssid  sid ab val s1 s2 tag vmid cdnz dss  sok cab cval exp nf rq
    '{2'b00,F,F,T,T,T,F,4'd0, T,F,T,T,T,T,4'd5, F,2'b00, T,F,T, 8'hFF,2'd0,4'd1},   // R1
    '{2'b01,F,F,F,T,T,F,4'd0, T,F,T,T,T,T,4'd5, F,2'b00, T,F,T, 8'hFF,2'd0,4'd2},   // R2
    '{2'b11,F,F,T,F,T,F,4'd0, T,F,T,T,T,T,4'd5, F,2'b00, T,F,T, 8'hFF,2'd0,4'd2},   // R2
    '{2'b10,T,F,T,T,T,F,4'd0, T,F,T,T,T,T,4'd5, F,2'b00, T,F,T, 8'hFF,2'd0,4'd3},   // R3
    '{2'b11,T,F,T,T,T,F,4'd0, T,F,T,T,T,T,4'd5, F,2'b00, T,F,T, 8'hFF,2'd0,4'd3},   // R3
    '{2'b10,F,F,T,T,T,T,4'd2, T,F,T,T,T,T,4'd5, F,2'b00, T,F,T, 8'hFF,2'd0,4'd4},   // R4
    '{2'b10,F,T,T,T,F,F,4'd0, F,F,T,T,T,T,4'd5, F,2'b00, T,F,T, 8'hFE,2'd0,4'd5},   // R5 before bad stream id
    '{2'b01,F,T,T,T,F,F,4'd0, T,F,T,T,T,T,4'd5, F,2'b00, T,F,T, 8'h00,2'd2,4'd5},   // R5 stage1 unaffected
    '{2'b10,F,T,T,T,T,F,4'd0, T,F,T,T,T,T,4'd5, F,2'b00, T,F,T, 8'h00,2'd1,4'd5},   // R5 secure s2 ok
    '{2'b01,F,F,T,T,T,F,4'd0, F,T,F,F,F,F,4'd0, F,2'b00, F,F,T, 8'h02,2'd1,4'd6},   // R6
    '{2'b01,F,F,T,T,T,F,4'd0, T,T,F,F,F,F,4'd0, F,2'b00, F,F,T, 8'h03,2'd1,4'd6},   // R6
    '{2'b11,F,F,T,T,T,F,4'd0, T,F,F,F,F,T,4'd5, F,2'b00, F,F,T, 8'h04,2'd1,4'd6},   // R6
    '{2'b01,T,F,T,T,T,F,4'd0, T,F,T,T,F,F,4'd5, F,2'b00, T,F,T, 8'h04,2'd1,4'd7},   // R7 no tag
    '{2'b01,T,F,T,T,T,F,4'd0, T,F,T,T,F,T,4'd6, F,2'b00, T,F,T, 8'h04,2'd1,4'd7},   // R7 mismatch
    '{2'b01,T,F,T,T,T,F,4'd0, T,F,T,T,T,T,4'd5, F,2'b00, T,F,T, 8'h00,2'd2,4'd7},   // R7 match
    '{2'b01,T,F,T,T,T,F,4'd0, T,F,T,F,T,T,4'd6, F,2'b00, T,F,T, 8'h04,2'd1,4'd7},   // R7 above stage
    '{2'b01,T,F,T,T,T,F,4'd0, T,F,T,F,T,T,4'd5, F,2'b00, T,F,T, 8'hFE,2'd1,4'd8},   // R8
    '{2'b11,F,F,T,T,T,F,4'd0, T,F,T,T,F,T,4'd5, F,2'b00, T,F,T, 8'hFE,2'd1,4'd8},   // R8
    '{2'b10,F,F,T,T,T,F,4'd0, T,F,T,T,F,T,4'd5, F,2'b00, T,F,T, 8'hFE,2'd1,4'd8},   // R8
    '{2'b01,F,F,T,T,T,T,4'd0, T,F,T,T,F,T,4'd5, T,2'b10, F,F,T, 8'h08,2'd1,4'd9},   // R9 beats disabled
    '{2'b01,F,F,T,T,T,F,4'd0, T,F,T,T,F,T,4'd5, T,2'b00, T,F,T, 8'h06,2'd1,4'd9},   // R9
    '{2'b01,F,F,T,T,T,T,4'd0, T,F,T,T,F,T,4'd5, T,2'b10, T,F,T, 8'h06,2'd1,4'd9},   // R9
    '{2'b01,F,F,T,T,T,T,4'd3, T,F,T,T,F,T,4'd5, T,2'b10, T,F,T, 8'h00,2'd2,4'd9},   // R9 nonzero ssid
    '{2'b01,F,F,T,T,T,F,4'd0, T,F,T,T,T,T,4'd5, F,2'b00, T,T,F, 8'h09,2'd2,4'd10},  // R10
    '{2'b11,F,F,T,T,T,F,4'd0, T,F,T,T,T,T,4'd5, F,2'b00, T,F,F, 8'h0A,2'd2,4'd10},  // R10
    '{2'b10,F,F,T,T,T,F,4'd0, T,F,T,T,T,T,4'd5, F,2'b00, T,T,F, 8'h00,2'd1,4'd10},  // R10 no CD for s2
    '{2'b01,F,F,T,T,T,F,4'd0, T,F,T,T,F,T,4'd5, T,2'b01, T,T,F, 8'h00,2'd1,4'd10},  // R10 bypass
    '{2'b11,F,F,T,T,T,F,4'd0, T,F,T,T,T,T,4'd5, F,2'b00, T,F,T, 8'h00,2'd2,4'd12}   // R12
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_virt = 1'b0, req_secure = 1'b0, ssid_valid = 1'b0;
  logic [1:0] req_type = 2'b00;
  logic [19:0] ssid = '0;
  logic cap_s1 = 1'b1, cap_s2 = 1'b1, cap_sec_s2 = 1'b1;
  logic [15:0] sel_vmid = 16'd5, ste_vmid = '0;
  logic ste_rsp_valid = 1'b0, ste_sid_ok = 1'b0, ste_abort = 1'b0, ste_valid = 1'b0;
  logic ste_s1_en = 1'b0, ste_s2_en = 1'b0, ste_vmid_tag = 1'b0, ste_cdmax_nz = 1'b0;
  logic [1:0] ste_dss = 2'b00;
  logic ste_ssid_ok = 1'b0, cd_rsp_valid = 1'b0, cd_abort = 1'b0, cd_valid = 1'b0;
  logic busy, ste_req, cd_req, done, fault;
  logic [7:0] result_code;

  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  xlat_query_checker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_virt(req_virt), .req_secure(req_secure), .ssid_valid(ssid_valid),
    .ssid(ssid), .cap_s1(cap_s1), .cap_s2(cap_s2), .cap_sec_s2(cap_sec_s2),
    .sel_vmid(sel_vmid), .busy(busy), .ste_req(ste_req),
    .ste_rsp_valid(ste_rsp_valid), .ste_sid_ok(ste_sid_ok), .ste_abort(ste_abort),
    .ste_valid(ste_valid), .ste_s1_en(ste_s1_en), .ste_s2_en(ste_s2_en),
    .ste_vmid_tag(ste_vmid_tag), .ste_vmid(ste_vmid), .ste_cdmax_nz(ste_cdmax_nz),
    .ste_dss(ste_dss), .ste_ssid_ok(ste_ssid_ok), .cd_req(cd_req),
    .cd_rsp_valid(cd_rsp_valid), .cd_abort(cd_abort), .cd_valid(cd_valid),
    .done(done), .fault(fault), .result_code(result_code));

  task automatic check(input string rq, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", rq, got, exp);
    end
  endtask

  task automatic run(input vec_t v, input bit poke, output logic [7:0] code,
                     output logic flt, output int nf, output bit fin);
    nf = 0; fin = 0; code = 8'h00; flt = 1'b0;
    @(negedge clk);
    req_type = v.typ; req_virt = v.virt; req_secure = v.sec;
    cap_s1 = v.cs1; cap_s2 = v.cs2; cap_sec_s2 = v.css2;
    ssid_valid = v.sv; ssid = {16'd0, v.ssid};
    ste_sid_ok = v.sid_ok; ste_abort = v.s_ab; ste_valid = v.s_val;
    ste_s1_en = v.s1; ste_s2_en = v.s2; ste_vmid_tag = v.vtag;
    ste_vmid = {12'd0, v.vmid}; ste_cdmax_nz = v.cdnz; ste_dss = v.dss;
    ste_ssid_ok = v.ssid_ok; cd_abort = v.c_ab; cd_valid = v.c_val;
    req_valid = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      req_valid = 1'b0; ste_rsp_valid = 1'b0; cd_rsp_valid = 1'b0;
      if (done) begin
        code = result_code; flt = fault; fin = 1;
        break;
      end
      if (ste_req) begin
        ste_rsp_valid = 1'b1; nf++;
        if (poke) begin req_valid = 1'b1; req_type = 2'b00; end
      end else if (cd_req) begin
        cd_rsp_valid = 1'b1; nf++;
      end
    end
  endtask

  initial begin
    #(PERIOD*20000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] code;
    logic flt;
    int nf;
    bit fin;
    repeat (3) @(negedge clk);
    // reset state
    check("R12 reset done", int'(done), 0);
    check("R12 reset fault", int'(fault), 0);
    check("R11 reset busy", int'(busy), 0);
    check("R11 reset fetch", int'({ste_req, cd_req}), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", TBL[i].rq, i);
      run(TBL[i], 1'b0, code, flt, nf, fin);
      check({tag, " finished"}, int'(fin), 1);
      check({tag, " code"}, int'(code), int'(TBL[i].exp));
      check({tag, " fault"}, int'(flt), int'(TBL[i].exp != 8'h00));
      check({tag, " fetches"}, nf, int'(TBL[i].nf));
    end

    // R12: done lasts one cycle, result held afterwards
    run(TBL[27], 1'b0, code, flt, nf, fin);
    @(negedge clk);
    check("R12 done one cycle", int'(done), 0);
    check("R12 code held", int'(result_code), 0);

    // R13: start pulse while a fetch is pending is ignored
    run(TBL[14], 1'b1, code, flt, nf, fin);
    check("R13 ignored start code", int'(code), 0);
    check("R13 ignored start fetches", nf, 2);
    @(negedge clk);
    check("R13 no stray query", int'({busy, done}), 0);

    // R11: fault after entry issues no context fetch, then quiet
    run(TBL[20], 1'b0, code, flt, nf, fin);
    repeat (3) @(negedge clk);
    check("R11 quiet after fault", int'({ste_req, cd_req, busy}), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule